// File: doc/BRIEF.md
# Adaptive Vertical Divider Window Controller

This block derives field timing for a raster display from a clock that runs at twice the line rate, so one scan line is two clock cycles. A single half-line counter is restarted either by an accepted vertical sync pulse or by a flywheel rule when no sync arrives. The ratio at which a restart happens selects the field rate: 50 Hz near 625 half-lines, 60 Hz near 525.

How strictly sync is accepted depends on how much the block trusts the incoming signal. A saturating confidence counter (0 to 14) moves the controller between three modes. The wide search mode accepts almost any plausible ratio. The narrow mode accepts only a few half-lines around the locked norm. The standard mode ignores sync timing and always restarts at the nominal ratio, which gives a steady picture from sources with disturbed sync. The counter value also produces the anti-top-flutter pulse, the vertical blanking pulse, their combined sandcastle blanking level and the gate for the sawtooth charge period.

All pins are plain control and status signals sampled on the clock. There is no data stream, so no valid/ready handshake and no back-pressure. Every clock cycle is one half-line step.

Top module: `vdiv_win_ctrl`

## Requirements
- R1: The divider count advances by one per clock and returns to 0 at each divider restart. In search mode a sync pulse sampled at count 488 to 722 restarts the divider. A sync at any other count is ignored. With no accepted sync the divider restarts at count 722.
- R2: At each restart the confidence counter rises by one for an accepted sync that counts as confirming and falls by one for a missed sync. It saturates at 0 and 14. In search mode a sync is confirming if its count lies in 522 to 528 or in 622 to 628; any other accepted sync clears the counter to 0. Search mode changes to narrow mode (mode_o = 1) when the counter reaches 12.
- R3: In narrow mode only a sync at count 622 to 628 (50 Hz) or 522 to 528 (60 Hz) is accepted. The window follows the current rate flag. If no sync is accepted, the divider restarts at the last count of the window (628 or 528) and the counter falls. When the counter drops to 0 the mode returns to search.
- R4: In narrow mode, while the counter is 12 or more, only a sync at exactly the standard count (625 for 50 Hz, 525 for 60 Hz) raises it. Other in-window syncs leave it unchanged. Reaching 14 selects standard mode (mode_o = 2). Search mode never goes directly to standard mode.
- R5: In standard mode the divider always restarts at the standard count. A sync exactly there raises the counter. Otherwise the counter falls, and at 10 or below the mode returns to search. Sync at any other count has no effect.
- R6: When no_tx_i is high and no sync pulse of any timing has been seen since the last restart, the divider restarts at count 628 unless another rule restarts it first. Any sync seen in the field suppresses this default.
- R7: is50_o is 1 after reset. At each sync-accepted restart it takes 1 if the count was 575 or more and 0 otherwise. Flywheel and default restarts leave it unchanged.
- R8: atf_o is high from count 0 up to count 7 (50 Hz) or 9 (60 Hz). In narrow and standard modes it is also high from 6 half-lines before the standard count until the restart.
- R9: vblank_o is high from count 0 up to count 43 (50 Hz) or 33 (60 Hz). sc_blank_o is high when vblank_o or atf_o is high.
- R10: charge_o is high for the first 26 counts (0 to 25) of each field.
- R11: While force_srch_i is high, decoding uses search mode. mode_o reads 0 from the next cycle on, and the confidence counter is held at 0.
- R12: div_rst_o is a one-cycle pulse in the cycle where the count is 0 after a restart. During reset, div_rst_o is 0, mode_o is 0, is50_o is 1, and vblank_o, atf_o, sc_blank_o and charge_o are 1. mode_o uses 0 for search, 1 for narrow and 2 for standard, and never reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Separated vertical sync, one cycle per pulse |
| no_tx_i | input | 1 | No transmitter present |
| force_srch_i | input | 1 | Hold the controller in search mode |
| div_rst_o | output | 1 | Divider restart pulse |
| mode_o | output | 2 | 0 search, 1 narrow, 2 standard |
| is50_o | output | 1 | 1 for 50 Hz, 0 for 60 Hz |
| atf_o | output | 1 | Anti-top-flutter pulse |
| vblank_o | output | 1 | Vertical blanking pulse |
| sc_blank_o | output | 1 | Combined blanking level for the sandcastle |
| charge_o | output | 1 | Sawtooth charge-period gate |

## Verification
A corrupted divider count shows within the same field: the spacing of div_rst_o pulses moves, and so do the ends of the blanking, flutter and charge pulses. A wrong confidence value stays hidden until it shifts a mode change, which can take up to fourteen fields. The bench therefore checks the mode after exact sequences of accepted, confirming and missed syncs, including both saturation limits. A wrong rate flag shows one field later as wrong pulse widths and wrong window ends.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;

  typedef enum logic [1:0] {
    MODE_SEARCH = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_STD    = 2'd2
  } vdiv_mode_e;

endpackage

// File: rtl/vdiv_halfline_ctr.sv
module vdiv_halfline_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_i,
  input  logic             rst_evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             div_rst_o,
  output logic             sync_seen_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (rst_evt_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
      seen_q  <= 1'b0;
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
      seen_q  <= seen_q | vsync_i;
    end
  end

  assign cnt_o       = cnt_q;
  assign div_rst_o   = pulse_q;
  assign sync_seen_o = seen_q;

endmodule

// File: rtl/vdiv_lock_ctl.sv
module vdiv_lock_ctl
  import vdiv_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int CONF_W      = 4,
  parameter int SRCH_LO     = 488,
  parameter int SRCH_HI     = 722,
  parameter int N60_LO      = 522,
  parameter int N60_HI      = 528,
  parameter int N50_LO      = 622,
  parameter int N50_HI      = 628,
  parameter int STD60       = 525,
  parameter int STD50       = 625,
  parameter int NOSIG_CNT   = 628,
  parameter int RATE_SPLIT  = 575,
  parameter int CONF_NARROW = 12,
  parameter int CONF_TOP    = 14,
  parameter int CONF_DROP   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             vsync_i,
  input  logic             no_tx_i,
  input  logic             force_i,
  input  logic             sync_seen_i,
  output logic             rst_evt_o,
  output vdiv_mode_e       mode_o,
  output logic             is50_o
);

  localparam logic [CNT_W-1:0]  L_SRCH_LO = CNT_W'(SRCH_LO);
  localparam logic [CNT_W-1:0]  L_SRCH_HI = CNT_W'(SRCH_HI);
  localparam logic [CNT_W-1:0]  L_N60_LO  = CNT_W'(N60_LO);
  localparam logic [CNT_W-1:0]  L_N60_HI  = CNT_W'(N60_HI);
  localparam logic [CNT_W-1:0]  L_N50_LO  = CNT_W'(N50_LO);
  localparam logic [CNT_W-1:0]  L_N50_HI  = CNT_W'(N50_HI);
  localparam logic [CNT_W-1:0]  L_STD60   = CNT_W'(STD60);
  localparam logic [CNT_W-1:0]  L_STD50   = CNT_W'(STD50);
  localparam logic [CNT_W-1:0]  L_NOSIG   = CNT_W'(NOSIG_CNT);
  localparam logic [CNT_W-1:0]  L_SPLIT   = CNT_W'(RATE_SPLIT);
  localparam logic [CONF_W-1:0] L_C_NAR   = CONF_W'(CONF_NARROW);
  localparam logic [CONF_W-1:0] L_C_TOP   = CONF_W'(CONF_TOP);
  localparam logic [CONF_W-1:0] L_C_DROP  = CONF_W'(CONF_DROP);

  vdiv_mode_e        mode_q, mode_n, eff_mode;
  logic [CONF_W-1:0] conf_q, conf_n, conf_up, conf_dn;
  logic              is50_q, is50_n;
  logic [CNT_W-1:0]  std_v, wnd_lo, wnd_hi;
  logic              in_srch, in_any_nar, in_wnd;
  logic              acc, miss, dflt;

  always_comb begin
    eff_mode   = force_i ? MODE_SEARCH : mode_q;
    std_v      = is50_q ? L_STD50 : L_STD60;
    wnd_lo     = is50_q ? L_N50_LO : L_N60_LO;
    wnd_hi     = is50_q ? L_N50_HI : L_N60_HI;
    in_srch    = (cnt_i >= L_SRCH_LO) && (cnt_i <= L_SRCH_HI);
    in_any_nar = ((cnt_i >= L_N50_LO) && (cnt_i <= L_N50_HI)) ||
                 ((cnt_i >= L_N60_LO) && (cnt_i <= L_N60_HI));
    in_wnd     = (cnt_i >= wnd_lo) && (cnt_i <= wnd_hi);

    case (eff_mode)
      MODE_SEARCH: begin
        acc  = vsync_i && in_srch;
        miss = !acc && (cnt_i == L_SRCH_HI);
      end
      MODE_NARROW: begin
        acc  = vsync_i && in_wnd;
        miss = !acc && (cnt_i == wnd_hi);
      end
      default: begin
        acc  = vsync_i && (cnt_i == std_v);
        miss = !vsync_i && (cnt_i == std_v);
      end
    endcase
    dflt = no_tx_i && !sync_seen_i && !vsync_i && (cnt_i == L_NOSIG) && !acc && !miss;

    conf_up = (conf_q >= L_C_TOP) ? L_C_TOP : conf_q + 1'b1;
    conf_dn = (conf_q == '0) ? '0 : conf_q - 1'b1;

    conf_n = conf_q;
    is50_n = is50_q;
    mode_n = eff_mode;
    if (acc) begin
      is50_n = (cnt_i >= L_SPLIT);
      case (eff_mode)
        MODE_SEARCH: conf_n = in_any_nar ? conf_up : '0;
        MODE_NARROW: conf_n = ((conf_q < L_C_NAR) || (cnt_i == std_v)) ? conf_up : conf_q;
        default:     conf_n = conf_up;
      endcase
    end else if (miss || dflt) begin
      conf_n = conf_dn;
    end

    if (acc || miss || dflt) begin
      case (eff_mode)
        MODE_SEARCH: if (conf_n >= L_C_NAR) mode_n = MODE_NARROW;
        MODE_NARROW: begin
          if (conf_n >= L_C_TOP)   mode_n = MODE_STD;
          else if (conf_n == '0)   mode_n = MODE_SEARCH;
        end
        default:     if (conf_n <= L_C_DROP) mode_n = MODE_SEARCH;
      endcase
    end

    if (force_i) begin
      mode_n = MODE_SEARCH;
      conf_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SEARCH;
      conf_q <= '0;
      is50_q <= 1'b1;
    end else begin
      mode_q <= mode_n;
      conf_q <= conf_n;
      is50_q <= is50_n;
    end
  end

  assign rst_evt_o = acc | miss | dflt;
  assign mode_o    = mode_q;
  assign is50_o    = is50_q;

endmodule

// File: rtl/vdiv_pulse_gen.sv
module vdiv_pulse_gen
  import vdiv_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int STD60   = 525,
  parameter int STD50   = 625,
  parameter int EQ_LEAD = 6,
  parameter int ATF50   = 8,
  parameter int ATF60   = 10,
  parameter int BLK50   = 44,
  parameter int BLK60   = 34,
  parameter int CHG_LEN = 26
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  vdiv_mode_e       mode_i,
  input  logic             is50_i,
  output logic             atf_o,
  output logic             vblank_o,
  output logic             sc_blank_o,
  output logic             charge_o
);

  localparam logic [CNT_W-1:0] L_EQ50  = CNT_W'(STD50 - EQ_LEAD);
  localparam logic [CNT_W-1:0] L_EQ60  = CNT_W'(STD60 - EQ_LEAD);
  localparam logic [CNT_W-1:0] L_ATF50 = CNT_W'(ATF50);
  localparam logic [CNT_W-1:0] L_ATF60 = CNT_W'(ATF60);
  localparam logic [CNT_W-1:0] L_BLK50 = CNT_W'(BLK50);
  localparam logic [CNT_W-1:0] L_BLK60 = CNT_W'(BLK60);
  localparam logic [CNT_W-1:0] L_CHG   = CNT_W'(CHG_LEN);

  logic [CNT_W-1:0] atf_end, blk_end, eq_start;
  logic             lead_on;

  always_comb begin
    atf_end  = is50_i ? L_ATF50 : L_ATF60;
    blk_end  = is50_i ? L_BLK50 : L_BLK60;
    eq_start = is50_i ? L_EQ50 : L_EQ60;
    lead_on  = (mode_i != MODE_SEARCH) && (cnt_i >= eq_start);
    atf_o    = (cnt_i < atf_end) || lead_on;
    vblank_o = cnt_i < blk_end;
    sc_blank_o = vblank_o | atf_o;
    charge_o = cnt_i < L_CHG;
  end

endmodule

// File: rtl/vdiv_win_ctrl.sv
module vdiv_win_ctrl
  import vdiv_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int CONF_W      = 4,
  parameter int SRCH_LO     = 488,
  parameter int SRCH_HI     = 722,
  parameter int N60_LO      = 522,
  parameter int N60_HI      = 528,
  parameter int N50_LO      = 622,
  parameter int N50_HI      = 628,
  parameter int STD60       = 525,
  parameter int STD50       = 625,
  parameter int NOSIG_CNT   = 628,
  parameter int RATE_SPLIT  = 575,
  parameter int CONF_NARROW = 12,
  parameter int CONF_TOP    = 14,
  parameter int CONF_DROP   = 10,
  parameter int EQ_LEAD     = 6,
  parameter int ATF50       = 8,
  parameter int ATF60       = 10,
  parameter int BLK50       = 44,
  parameter int BLK60       = 34,
  parameter int CHG_LEN     = 26
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vsync_i,
  input  logic       no_tx_i,
  input  logic       force_srch_i,
  output logic       div_rst_o,
  output logic [1:0] mode_o,
  output logic       is50_o,
  output logic       atf_o,
  output logic       vblank_o,
  output logic       sc_blank_o,
  output logic       charge_o
);

  logic [CNT_W-1:0] cnt_w;
  logic             rst_evt_w;
  logic             seen_w;
  vdiv_mode_e       mode_w;
  logic             is50_w;

  vdiv_halfline_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync_i    (vsync_i),
    .rst_evt_i  (rst_evt_w),
    .cnt_o      (cnt_w),
    .div_rst_o  (div_rst_o),
    .sync_seen_o(seen_w)
  );

  vdiv_lock_ctl #(
    .CNT_W(CNT_W), .CONF_W(CONF_W),
    .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
    .N60_LO(N60_LO), .N60_HI(N60_HI), .N50_LO(N50_LO), .N50_HI(N50_HI),
    .STD60(STD60), .STD50(STD50), .NOSIG_CNT(NOSIG_CNT), .RATE_SPLIT(RATE_SPLIT),
    .CONF_NARROW(CONF_NARROW), .CONF_TOP(CONF_TOP), .CONF_DROP(CONF_DROP)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_w),
    .vsync_i    (vsync_i),
    .no_tx_i    (no_tx_i),
    .force_i    (force_srch_i),
    .sync_seen_i(seen_w),
    .rst_evt_o  (rst_evt_w),
    .mode_o     (mode_w),
    .is50_o     (is50_w)
  );

  vdiv_pulse_gen #(
    .CNT_W(CNT_W), .STD60(STD60), .STD50(STD50), .EQ_LEAD(EQ_LEAD),
    .ATF50(ATF50), .ATF60(ATF60), .BLK50(BLK50), .BLK60(BLK60), .CHG_LEN(CHG_LEN)
  ) u_pulse (
    .cnt_i     (cnt_w),
    .mode_i    (mode_w),
    .is50_i    (is50_w),
    .atf_o     (atf_o),
    .vblank_o  (vblank_o),
    .sc_blank_o(sc_blank_o),
    .charge_o  (charge_o)
  );

  assign mode_o = mode_w;
  assign is50_o = is50_w;

endmodule

// File: rtl/vdiv_win_ctrl_chk.sv
module vdiv_win_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_srch_i,
  input logic       div_rst_o,
  input logic [1:0] mode_o,
  input logic       is50_o,
  input logic       vblank_o,
  input logic       charge_o
);

  // R12
  div_rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst_o |=> !div_rst_o);

  // R12
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  // R11
  force_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_srch_i |=> (mode_o == 2'd0));

  // R4
  no_skip_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |=> (mode_o != 2'd2));

  // R2
  mode_at_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> (div_rst_o || $past(force_srch_i)));

  // R7
  rate_at_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(is50_o) |-> div_rst_o);

  // R10
  charge_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    charge_o |-> vblank_o);

endmodule

bind vdiv_win_ctrl vdiv_win_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .force_srch_i(force_srch_i),
  .div_rst_o   (div_rst_o),
  .mode_o      (mode_o),
  .is50_o      (is50_o),
  .vblank_o    (vblank_o),
  .charge_o    (charge_o)
);

// File: tb/test_vdiv_win_ctrl.sv
module test_vdiv_win_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n, vsync, no_tx, force_srch;
  logic div_rst, is50, atf, vblank, sc_blank, charge;
  logic [1:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  int per, c_atf, c_blk, c_sc, c_chg;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdiv_win_ctrl i_vdiv_win_ctrl (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .no_tx_i(no_tx),
    .force_srch_i(force_srch), .div_rst_o(div_rst), .mode_o(mode),
    .is50_o(is50), .atf_o(atf), .vblank_o(vblank), .sc_blank_o(sc_blank),
    .charge_o(charge)
  );

  typedef struct packed {
    logic [3:0] tag;
    logic [3:0] reps;
    logic [9:0] ratio;   // 0 = no sync in the field
    logic [9:0] per;     // expected cycles between restarts
    logic [1:0] mode;
    logic       is50;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [NVEC] = '{
    '{4'd2, 4'd11, 10'd625, 10'd626, 2'd0, 1'b1},  // R1 R2 confirming syncs
    '{4'd2, 4'd1,  10'd625, 10'd626, 2'd1, 1'b1},  // R2 reach 12 -> narrow
    '{4'd4, 4'd1,  10'd625, 10'd626, 2'd1, 1'b1},  // R4 13
    '{4'd4, 4'd1,  10'd625, 10'd626, 2'd2, 1'b1},  // R4 14 -> standard
    '{4'd5, 4'd3,  10'd0,   10'd626, 2'd2, 1'b1},  // R5 flywheel, 11
    '{4'd5, 4'd1,  10'd0,   10'd626, 2'd0, 1'b1},  // R5 10 -> search
    '{4'd7, 4'd1,  10'd600, 10'd601, 2'd0, 1'b1},  // R7 R2 clears conf
    '{4'd7, 4'd1,  10'd525, 10'd526, 2'd0, 1'b0},  // R7 60 Hz
    '{4'd1, 4'd1,  10'd0,   10'd723, 2'd0, 1'b0},  // R1 search miss
    '{4'd1, 4'd1,  10'd400, 10'd723, 2'd0, 1'b0},  // R1 outside ignored, R2 floor
    '{4'd2, 4'd11, 10'd525, 10'd526, 2'd0, 1'b0},  // R2 build to 11
    '{4'd2, 4'd1,  10'd525, 10'd526, 2'd1, 1'b0},  // R2 narrow 60
    '{4'd4, 4'd1,  10'd527, 10'd528, 2'd1, 1'b0},  // R4 non-standard holds 12
    '{4'd3, 4'd1,  10'd500, 10'd529, 2'd1, 1'b0},  // R3 outside, end of window
    '{4'd3, 4'd1,  10'd522, 10'd523, 2'd1, 1'b0},  // R3 window edge
    '{4'd4, 4'd2,  10'd525, 10'd526, 2'd2, 1'b0},  // R4 -> standard
    '{4'd5, 4'd1,  10'd520, 10'd526, 2'd2, 1'b0},  // R5 early sync ignored
    '{4'd5, 4'd1,  10'd525, 10'd526, 2'd2, 1'b0},  // R5
    '{4'd2, 4'd1,  10'd525, 10'd526, 2'd2, 1'b0}   // R2 ceiling
  };

  task automatic chk(input int tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Starts at a falling edge where the count is 0; returns at the falling
  // edge where the next restart pulse is visible.
  task automatic run_field(input int r);
    int k;
    k = 0; per = 0; c_atf = 0; c_blk = 0; c_sc = 0; c_chg = 0;
    while (k < 2000) begin
      c_atf += int'(atf); c_blk += int'(vblank);
      c_sc  += int'(sc_blank); c_chg += int'(charge);
      vsync = (r > 0) && (k == r);
      @(negedge clk);
      k++;
      if (div_rst) begin
        per = k;
        break;
      end
    end
    vsync = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vsync = 1'b0; no_tx = 1'b0; force_srch = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(12, "reset div_rst", int'(div_rst), 0);
    chk(12, "reset mode",    int'(mode), 0);
    chk(12, "reset is50",    int'(is50), 1);
    chk(12, "reset vblank",  int'(vblank), 1);
    chk(12, "reset atf",     int'(atf), 1);
    chk(12, "reset sc",      int'(sc_blank), 1);
    chk(12, "reset charge",  int'(charge), 1);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      for (int j = 0; j < int'(VEC[v].reps); j++) begin
        run_field(int'(VEC[v].ratio));
        chk(int'(VEC[v].tag), $sformatf("vec %0d period", v), per, int'(VEC[v].per));
        chk(12, $sformatf("vec %0d pulse width", v), int'(div_rst), 1);
      end
      chk(int'(VEC[v].tag), $sformatf("vec %0d mode", v), int'(mode), int'(VEC[v].mode));
      chk(7, $sformatf("vec %0d rate flag", v), int'(is50), int'(VEC[v].is50));
    end

    // R8 R9 R10: standard 60 Hz field widths
    run_field(525);
    chk(5,  "std60 period", per, 526);
    chk(8,  "std60 atf count", c_atf, 17);
    chk(9,  "std60 vblank count", c_blk, 34);
    chk(9,  "std60 sc count", c_sc, 41);
    chk(10, "std60 charge count", c_chg, 26);

    // R11: force search, first field still at 60 Hz widths
    force_srch = 1'b1;
    run_field(625);
    chk(11, "forced period", per, 626);
    chk(11, "forced mode", int'(mode), 0);
    chk(7,  "forced rate flag", int'(is50), 1);
    run_field(625);
    chk(8,  "search50 atf count", c_atf, 8);
    chk(9,  "search50 vblank count", c_blk, 44);
    chk(9,  "search50 sc count", c_sc, 44);
    chk(10, "search50 charge count", c_chg, 26);
    chk(11, "forced mode held", int'(mode), 0);
    force_srch = 1'b0;

    // R6: no-transmitter default restart and its suppression
    no_tx = 1'b1;
    run_field(0);
    chk(6, "no_tx default period", per, 629);
    chk(7, "no_tx flag kept", int'(is50), 1);
    run_field(400);
    chk(6, "no_tx suppressed period", per, 723);
    run_field(600);
    chk(6, "no_tx accepted period", per, 601);
    chk(6, "no_tx mode", int'(mode), 0);
    no_tx = 1'b0;

    // R11: confidence was held at 0 during force -> eleven confirming fields
    // stay in search, the twelfth locks
    run_field(625);
    for (int j = 0; j < 10; j++) run_field(625);
    chk(11, "after force 11 fields mode", int'(mode), 0);
    run_field(625);
    chk(2, "after force 12 fields mode", int'(mode), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule